// File: doc/BRIEF.md
# Colour Lookup Table Load Port

This block holds a colour lookup table of up to 256 entries, each made of a 6-bit red, a 6-bit green and a 6-bit blue component. The host loads the table through two write ports. A write on the index port selects the entry to load. After that, each write on the data port supplies one component, and the components arrive in a fixed order.

Once an entry's third component arrives, the whole entry is written to the table at once. The load pointer then moves to the next entry, so a run of consecutive entries needs only one index write. To blank the first 16 colours, the host sets the index to zero and streams 48 zero bytes.

On the display side, a pixel value is ANDed with a separately written pixel mask. The result addresses the table, and the selected entry comes out as an 18-bit RGB word one clock later.

Top module: `pal_dac_wport`

## Requirements
- R1: While reset is asserted, `pix_rgb` is 0. After reset the load index is 0, the next data write is taken as red, and the pixel mask is 8'hFF.
- R2: A pulse on `idx_we` loads `idx_wdata` as the load index and sets the next data write to be the red component.
- R3: Data writes are taken as red, then green, then blue. The table entry changes only when the blue write arrives, and it then receives all three components together.
- R4: After the blue write the load index increases by one, with 255 wrapping to 0, and the next data write is red again.
- R5: An index write in the middle of an entry discards the red and green already received. When `idx_we` and `dat_we` are both high in the same cycle, the index write takes effect and the data byte is dropped.
- R6: Only bits [5:0] of `dat_wdata` are stored. Bits [7:6] have no effect.
- R7: `pix_rgb` carries red in [17:12], green in [11:6] and blue in [5:0] of the entry addressed by `pix_in & mask`. It updates on the clock edge that samples `pix_in`.
- R8: A pulse on `mask_we` loads `mask_wdata` as the pixel mask, which is used from the next cycle on. A mask of 0 always selects entry 0.
- R9: Writing 48 zero bytes from index 0 makes entries 0 to 15 read as 0 and leaves entry 16 unchanged.
- R10: In a cycle with neither `idx_we` nor `dat_we`, the load index and the component position keep their values, so a partly loaded entry can resume later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| idx_we | input | 1 | Load-index write strobe |
| idx_wdata | input | 8 | New load index |
| dat_we | input | 1 | Component write strobe |
| dat_wdata | input | 8 | Component value; bits [5:0] are used |
| mask_we | input | 1 | Pixel-mask write strobe |
| mask_wdata | input | 8 | New pixel mask |
| pix_in | input | 8 | Pixel value to look up |
| pix_rgb | output | 18 | Registered RGB of the addressed entry |

## Verification
The checker watches the load sequencer on every cycle. It confirms that an index write loads the pointer and restarts at red, that the component position never takes an unused code, and that a blue write always advances the pointer by one. It also confirms that idle cycles change neither the pointer nor the position, and that the mask changes only when written. The contents of the table can only be shown by the bench scenarios, which read back through the lookup port. These scenarios cover auto-increment across the 255-to-0 wrap, discarding a partial entry, dropping the upper data bits, masking and blanking.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;
endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8,
  localparam int WORD_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic [IDX_W-1:0]  idx_wdata,
  input  logic              dat_we,
  input  logic [BUS_W-1:0]  dat_wdata,
  output logic [1:0]        phase_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              tbl_we_o,
  output logic [WORD_W-1:0] tbl_wdata_o
);
  phase_e              phase_q, phase_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [COMP_W-1:0]   red_q, red_d, grn_q, grn_d;
  logic [COMP_W-1:0]   comp;
  logic                seq_en;

  assign comp   = dat_wdata[COMP_W-1:0];
  assign seq_en = idx_we | dat_we;

  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    red_d    = red_q;
    grn_d    = grn_q;
    tbl_we_o = 1'b0;
    if (idx_we) begin
      idx_d   = idx_wdata;
      phase_d = PH_RED;
    end else if (dat_we) begin
      unique case (phase_q)
        PH_RED: begin
          red_d   = comp;
          phase_d = PH_GREEN;
        end
        PH_GREEN: begin
          grn_d   = comp;
          phase_d = PH_BLUE;
        end
        PH_BLUE: begin
          tbl_we_o = 1'b1;
          idx_d    = idx_q + 1'b1;
          phase_d  = PH_RED;
        end
        default: phase_d = PH_RED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RED;
      idx_q   <= '0;
      red_q   <= '0;
      grn_q   <= '0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      red_q   <= red_d;
      grn_q   <= grn_d;
    end
  end

  assign tbl_wdata_o = {red_q, grn_q, comp};
  assign phase_o     = phase_q;
  assign wr_idx_o    = idx_q;
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int WORD_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_mask.sv
module pal_mask #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [IDX_W-1:0] mask_wdata,
  input  logic [IDX_W-1:0] pix_in,
  output logic [IDX_W-1:0] mask_o,
  output logic [IDX_W-1:0] raddr
);
  logic [IDX_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign raddr  = pix_in & mask_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/pal_dac_wport.sv
module pal_dac_wport #(
  parameter int ENTRIES = 256,
  parameter int COMP_W  = 6,
  parameter int BUS_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RGB_W  = 3 * COMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_wdata,
  input  logic             dat_we,
  input  logic [BUS_W-1:0] dat_wdata,
  input  logic             mask_we,
  input  logic [IDX_W-1:0] mask_wdata,
  input  logic [IDX_W-1:0] pix_in,
  output logic [RGB_W-1:0] pix_rgb
);
  logic             rst_sn;
  logic [1:0]       phase_w;
  logic [IDX_W-1:0] wr_idx_w;
  logic             tbl_we_w;
  logic [RGB_W-1:0] tbl_wdata_w;
  logic [IDX_W-1:0] mask_w;
  logic [IDX_W-1:0] raddr_w;

  pal_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .phase_o(phase_w), .wr_idx_o(wr_idx_w),
    .tbl_we_o(tbl_we_w), .tbl_wdata_o(tbl_wdata_w)
  );

  pal_mask #(.IDX_W(IDX_W)) u_mask (
    .clk(clk), .rst_n(rst_sn),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .pix_in(pix_in), .mask_o(mask_w), .raddr(raddr_w)
  );

  pal_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .WORD_W(RGB_W)) u_store (
    .clk(clk), .rst_n(rst_sn),
    .we(tbl_we_w), .waddr(wr_idx_w), .wdata(tbl_wdata_w),
    .raddr(raddr_w), .rdata(pix_rgb)
  );
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
  import pal_dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idx_we,
  input logic [IDX_W-1:0] idx_wdata,
  input logic             dat_we,
  input logic [1:0]       phase,
  input logic [IDX_W-1:0] wr_idx,
  input logic             tbl_we,
  input logic             mask_we,
  input logic [IDX_W-1:0] mask_wdata,
  input logic [IDX_W-1:0] mask_q
);
  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (wr_idx == $past(idx_wdata)) && (phase == PH_RED));

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'b11);

  p_red_to_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !idx_we && phase == PH_RED) |=> phase == PH_GREEN);

  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> (phase == PH_RED));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !idx_we && phase == PH_BLUE) |=>
      (wr_idx == IDX_W'($past(wr_idx) + 1'b1)) && (phase == PH_RED));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_we && !dat_we) |=> $stable(phase) && $stable(wr_idx));

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(mask_wdata));

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

bind pal_dac_wport pal_dac_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_sn),
  .idx_we(idx_we), .idx_wdata(idx_wdata), .dat_we(dat_we),
  .phase(phase_w), .wr_idx(wr_idx_w), .tbl_we(tbl_we_w),
  .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_q(mask_w)
);

// File: tb/pal_dac_wport_test.sv
`timescale 1ns/1ps
module pal_dac_wport_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        idx_we, dat_we, mask_we;
  logic [7:0]  idx_wdata, dat_wdata, mask_wdata, pix_in;
  logic [17:0] pix_rgb;

  always #2.5 clk = ~clk;

  pal_dac_wport uut (
    .clk(clk), .rst_n(rst_n),
    .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .pix_in(pix_in), .pix_rgb(pix_rgb)
  );

  int checks = 0;
  int failures = 0;

  logic [17:0] shadow [256];
  logic [7:0]  b_idx = 8'd0;
  int          b_ph = 0;
  logic [5:0]  b_r = '0, b_g = '0;
  logic [7:0]  b_mask = 8'hFF;

  logic [17:0] exp_q [$];
  string       tag_q [$];
  logic        req_v = 1'b0;

  task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic put_idx(input logic [7:0] i);
    idx_we = 1'b1; idx_wdata = i;
    b_idx = i; b_ph = 0;
    @(negedge clk);
    idx_we = 1'b0;
  endtask

  task automatic put_dat(input logic [7:0] d);
    dat_we = 1'b1; dat_wdata = d;
    case (b_ph)
      0: begin b_r = d[5:0]; b_ph = 1; end
      1: begin b_g = d[5:0]; b_ph = 2; end
      default: begin
        shadow[b_idx] = {b_r, b_g, d[5:0]};
        b_idx = b_idx + 8'd1; b_ph = 0;
      end
    endcase
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic put_both(input logic [7:0] i, input logic [7:0] d);
    idx_we = 1'b1; idx_wdata = i; dat_we = 1'b1; dat_wdata = d;
    b_idx = i; b_ph = 0;
    @(negedge clk);
    idx_we = 1'b0; dat_we = 1'b0;
  endtask

  task automatic put_rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    put_dat(r); put_dat(g); put_dat(b);
  endtask

  task automatic put_mask(input logic [7:0] m);
    mask_we = 1'b1; mask_wdata = m; b_mask = m;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic look(input logic [7:0] p, input string tag);
    pix_in = p; req_v = 1'b1;
    exp_q.push_back(shadow[p & b_mask]);
    tag_q.push_back(tag);
    @(negedge clk);
    req_v = 1'b0;
  endtask

  // monitor: a lookup presented before edge k is compared after edge k
  initial begin
    forever begin
      @(posedge clk);
      if (req_v) begin
        @(negedge clk);
        if (exp_q.size() > 0) check(tag_q.pop_front(), pix_rgb, exp_q.pop_front());
      end
    end
  end

  task automatic run_all();
    rst_n = 1'b0; idx_we = 0; dat_we = 0; mask_we = 0;
    idx_wdata = 0; dat_wdata = 0; mask_wdata = 0; pix_in = 0;
    repeat (4) @(negedge clk);
    check("R1 pix_rgb zero in reset", pix_rgb, 18'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: default index 0, red first
    put_rgb(8'h11, 8'h22, 8'h33);
    look(8'd0, "R1 default index 0");

    // R4: auto-increment from 5
    put_idx(8'd5);
    for (int k = 0; k < 6; k++) put_rgb(8'(k + 1), 8'(k + 10), 8'(k + 20));
    for (int k = 5; k < 11; k++) look(8'(k), "R4 auto increment");
    look(8'd7, "R7 component placement");

    // R4: wrap 255 -> 0
    put_idx(8'd255);
    put_rgb(8'h3F, 8'h00, 8'h15);
    put_rgb(8'h2A, 8'h15, 8'h3F);
    look(8'd255, "R1 default mask all ones / R4 entry 255");
    look(8'd0, "R4 wrap to entry 0");

    // R2: index load then entry 16
    put_idx(8'd16);
    put_rgb(8'h05, 8'h06, 8'h07);
    look(8'd16, "R2 index load");

    // R5: restart in the middle
    put_idx(8'd20);
    put_dat(8'h01); put_dat(8'h02);
    put_idx(8'd20);
    put_rgb(8'h30, 8'h31, 8'h32);
    look(8'd20, "R5 partial discarded");

    // R5: simultaneous index and data: data dropped
    put_both(8'd21, 8'h3E);
    put_rgb(8'h0A, 8'h0B, 8'h0C);
    look(8'd21, "R5 simultaneous write");

    // R6: upper bits ignored
    put_idx(8'd22);
    put_rgb(8'hFF, 8'hC1, 8'h40);
    look(8'd22, "R6 upper bits ignored");
    check("R6 literal value", shadow[22], {6'h3F, 6'h01, 6'h00});

    // R3: entry unchanged until blue
    put_idx(8'd30);
    put_rgb(8'h01, 8'h02, 8'h03);
    put_idx(8'd30);
    put_dat(8'h3F);
    look(8'd30, "R3 unchanged after red");
    put_dat(8'h3E);
    look(8'd30, "R3 unchanged after green");
    // R10: idle cycles keep the position
    repeat (5) @(negedge clk);
    put_dat(8'h3D);
    look(8'd30, "R10 resume after idle / R3 commit");
    put_rgb(8'h04, 8'h05, 8'h06);
    look(8'd31, "R10 index kept");

    // R8: mask
    put_mask(8'h0F);
    look(8'hF5, "R8 mask 0F");
    look(8'h17, "R8 mask 0F second");
    put_mask(8'h00);
    look(8'hAB, "R8 mask zero selects entry 0");
    put_mask(8'hFF);

    // R9: blanking first 16 entries
    put_idx(8'd0);
    for (int k = 0; k < 48; k++) put_dat(8'h00);
    for (int k = 0; k < 16; k++) look(8'(k), "R9 blanked entry");
    look(8'd16, "R9 entry 16 kept");
    check("R9 entry 16 model", shadow[16], {6'h05, 6'h06, 6'h07});

    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule